// File: doc/BRIEF.md
# USB Device Endpoint Status Controller

This block keeps the status of every endpoint of a full-speed USB device controller and acts on one-byte commands from a local processor. The processor can stall and unstall endpoints and can mark an IN buffer as ready to send. On double-buffered endpoints, marking a buffer ready also hands the processor the other buffer. The USB side reports four events: a SETUP token arrived, the SETUP data has been written, an IN packet was acknowledged, and an OUT packet was received. The block uses these events to track the data PID, to empty buffers that have been sent, and to keep the control endpoint's SETUP bookkeeping.

Each endpoint has its own status register. A read index selects which one drives the 8-bit status byte. Any re-initialisation of an endpoint raises a one-cycle flush pulse for that endpoint, so the packet memory can drop its contents. A SETUP token always forces both control endpoints (index 0 = control OUT, index 1 = control IN) out of the stalled state, whatever the packet contains.

The control endpoint's SETUP tracking is a three-state machine:
- `SU_IDLE` moves to `SU_WRITING` when a SETUP token arrives.
- `SU_WRITING` moves to `SU_HELD` when the write finishes. It moves to `SU_IDLE` on an unstall command for index 0. It re-enters `SU_WRITING` on a new SETUP token, which sets the overwrite flag.
- `SU_HELD` moves to `SU_IDLE` when the processor handles the packet with a stall or unstall command for index 0. It moves to `SU_WRITING` on a new SETUP token, which sets the overwrite flag.

Each endpoint's slice applies exactly one action per cycle: `ACT_HOLD`, `ACT_REINIT`, `ACT_STALL`, `ACT_VALIDATE`, `ACT_SEND` or `ACT_RECV`.

Top module: `epstat_ctrl`

## Requirements
- R1: After a synchronous reset every endpoint's status byte reads 0x00 and no flush pulse is active.
- R2: Command byte 0x40+n sets bit 7 (stalled) of endpoint n and changes no other bit. A stall of an endpoint that is already stalled changes nothing.
- R3: Command byte 0x80+n clears bits 7, 6, 5, 4 and 1 of endpoint n and raises flush_o[n] for exactly the cycle after the command. This happens even if endpoint n was not stalled.
- R4: Command byte 0x60+n, with n from 1 to 15, sets bit 5 (primary full) when bit 1 is 0, or bit 6 (secondary full) when bit 1 is 1. On a double-buffered endpoint (indices 2 to 15 by default) it also inverts bit 1. On a single-buffered endpoint bit 1 stays 0.
- R5: An in_sent_i pulse for endpoint n acts on the buffer the USB side is using, which starts at primary. If that buffer is full, the pulse clears its full bit and inverts bit 4 (data PID), and on a double-buffered endpoint the USB side moves to the other buffer. If that buffer is empty, the pulse changes nothing.
- R6: An out_rcvd_i pulse for endpoint n inverts bit 4 of endpoint n.
- R7: A setup_rcvd_i pulse re-initialises endpoints 0 and 1, as in R3, and raises flush_o[0] and flush_o[1] in the next cycle.
- R8: Bit 2 of endpoint 0 becomes 1 on setup_done_i after a SETUP token. It returns to 0 when a stall or unstall command for endpoint 0 handles the packet.
- R9: Bit 3 of endpoint 0 (overwrite) becomes 1 when a SETUP token arrives while an earlier SETUP is still being written or is held and not yet handled.
- R10: A read strobe with rd_ep_i = 0 returns the current status byte and then clears bit 3, unless a SETUP write is still in progress. In that case bit 3 stays 1.
- R11: Command bytes outside the ranges 0x40 to 0x4F, 0x61 to 0x6F and 0x80 to 0x8F change no status and raise no flush. This includes 0x60.
- R12: When several actions reach the same endpoint in one cycle, this priority applies: SETUP re-initialisation, then the command, then in_sent_i, then out_rcvd_i.
- R13: status_o shows the endpoint selected by rd_ep_i in the same cycle. Bit 0 is always 0, and bits 3 and 2 are 0 for every index other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | Command strobe from the processor |
| cmd_byte_i | input | 8 | Command byte |
| setup_rcvd_i | input | 1 | SETUP token received on the control endpoint |
| setup_done_i | input | 1 | SETUP data fully written to the buffer |
| in_sent_i | input | 1 | IN packet on usb_ep_i acknowledged by the host |
| out_rcvd_i | input | 1 | OUT packet on usb_ep_i received successfully |
| usb_ep_i | input | 4 | Endpoint index of the USB-side event |
| rd_strobe_i | input | 1 | Status read strobe (clears overwrite for index 0) |
| rd_ep_i | input | 4 | Endpoint index of the status read |
| status_o | output | 8 | Status byte of the selected endpoint |
| flush_o | output | 16 | One-cycle buffer flush pulse per endpoint |

## Verification
A slice that holds a wrong stall, full, PID or buffer-select value shows it on status_o as soon as rd_ep_i selects that endpoint. The register updates on the clock edge that samples the event, so the error is visible within one cycle. A wrong buffer pointer on the USB side is internal and has no status bit. It shows up one in_sent_i later, when the wrong full bit clears or the PID fails to toggle. A wrong SETUP machine state shows up in bits 2 and 3 of endpoint 0, either right away or at the next SETUP, setup_done_i or read strobe.

// File: rtl/epstat_pkg.sv
package epstat_pkg;

    // Bit positions of the status byte
    localparam int STS_W       = 8;
    localparam int BIT_STALL   = 7;
    localparam int BIT_FULL_S  = 6;
    localparam int BIT_FULL_P  = 5;
    localparam int BIT_PID     = 4;
    localparam int BIT_OVW     = 3;
    localparam int BIT_SETUP   = 2;
    localparam int BIT_CPUSEL  = 1;

    // Command families (upper nibble of the command byte)
    localparam logic [3:0] FAM_STALL    = 4'h4;
    localparam logic [3:0] FAM_VALIDATE = 4'h6;
    localparam logic [3:0] FAM_UNSTALL  = 4'h8;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_STALL,
        OP_UNSTALL,
        OP_VALIDATE
    } ep_op_e;

    typedef enum logic [1:0] {
        SU_IDLE,
        SU_WRITING,
        SU_HELD
    } setup_st_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_REINIT,
        ACT_STALL,
        ACT_VALIDATE,
        ACT_SEND,
        ACT_RECV
    } ep_act_e;

    typedef struct packed {
        logic stalled;
        logic full_sec;
        logic full_pri;
        logic pid;
        logic cpu_sel;
    } ep_state_t;

endpackage

// File: rtl/epstat_cmd_decode.sv
module epstat_cmd_decode
    import epstat_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int EPW = $clog2(NUM_EP)
) (
    input  logic           cmd_valid_i,
    input  logic [7:0]     cmd_byte_i,
    output ep_op_e         op_o,
    output logic [EPW-1:0] ep_o
);

    logic [3:0] fam;
    logic [3:0] idx;
    logic       in_range;

    assign fam      = cmd_byte_i[7:4];
    assign idx      = cmd_byte_i[3:0];
    assign in_range = (32'(idx) < NUM_EP);
    assign ep_o     = idx[EPW-1:0];

    always_comb begin
        op_o = OP_NONE;
        if (cmd_valid_i && in_range) begin
            unique case (fam)
                FAM_STALL:    op_o = OP_STALL;
                FAM_UNSTALL:  op_o = OP_UNSTALL;
                FAM_VALIDATE: op_o = (idx != 4'h0) ? OP_VALIDATE : OP_NONE;
                default:      op_o = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/epstat_ep_slice.sv
module epstat_ep_slice
    import epstat_pkg::*;
#(
    parameter bit DOUBLE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      reinit_i,
    input  logic      stall_i,
    input  logic      validate_i,
    input  logic      in_sent_i,
    input  logic      out_rcvd_i,
    output ep_state_t st_o,
    output logic      flush_o
);

    ep_state_t st_q, st_d;
    logic      usb_sel_q, usb_sel_d;
    logic      usb_full;
    logic      flush_d;
    ep_act_e   act;

    assign usb_full = usb_sel_q ? st_q.full_sec : st_q.full_pri;

    // Action selection with fixed priority
    always_comb begin
        act = ACT_HOLD;
        if (reinit_i)        act = ACT_REINIT;
        else if (stall_i)    act = ACT_STALL;
        else if (validate_i) act = ACT_VALIDATE;
        else if (in_sent_i)  act = usb_full ? ACT_SEND : ACT_HOLD;
        else if (out_rcvd_i) act = ACT_RECV;
    end

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        usb_sel_d = usb_sel_q;
        flush_d   = 1'b0;
        unique case (act)
            ACT_HOLD: ;
            ACT_REINIT: begin
                st_d      = '0;
                usb_sel_d = 1'b0;
                flush_d   = 1'b1;
            end
            ACT_STALL:
                st_d.stalled = 1'b1;
            ACT_VALIDATE: begin
                if (st_q.cpu_sel) st_d.full_sec = 1'b1;
                else              st_d.full_pri = 1'b1;
                if (DOUBLE)       st_d.cpu_sel  = ~st_q.cpu_sel;
            end
            ACT_SEND: begin
                if (usb_sel_q) st_d.full_sec = 1'b0;
                else           st_d.full_pri = 1'b0;
                st_d.pid = ~st_q.pid;
                if (DOUBLE)    usb_sel_d = ~usb_sel_q;
            end
            ACT_RECV:
                st_d.pid = ~st_q.pid;
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            usb_sel_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            usb_sel_q <= usb_sel_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) flush_o <= 1'b0;
        else     flush_o <= flush_d;
    end

    assign st_o = st_q;

    assert_stall_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !reinit_i) |=> st_q.stalled);

    assert_reinit_clears_R3: assert property (@(posedge clk) disable iff (rst)
        reinit_i |=> (st_q == '0) && flush_o);

    assert_validate_fills_R4: assert property (@(posedge clk) disable iff (rst)
        (validate_i && !reinit_i && !stall_i && !st_q.cpu_sel) |=> st_q.full_pri);

    assert_send_toggles_R5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SEND) |=> (st_q.pid != $past(st_q.pid)));

    assert_empty_send_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (in_sent_i && !reinit_i && !stall_i && !validate_i && !usb_full) |=> $stable(st_q));

endmodule

// File: rtl/epstat_setup_fsm.sv
module epstat_setup_fsm
    import epstat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic setup_rcvd_i,
    input  logic setup_done_i,
    input  logic ep0_stall_i,
    input  logic ep0_unstall_i,
    input  logic rd_clear_i,
    output logic holds_setup_o,
    output logic overwrite_o
);

    setup_st_e st_q, st_d;
    logic      ovw_q, ovw_d;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SU_IDLE:
                if (setup_rcvd_i) st_d = SU_WRITING;
            SU_WRITING:
                if (setup_rcvd_i)       st_d = SU_WRITING;
                else if (setup_done_i)  st_d = SU_HELD;
                else if (ep0_unstall_i) st_d = SU_IDLE;
            SU_HELD:
                if (setup_rcvd_i)                      st_d = SU_WRITING;
                else if (ep0_stall_i || ep0_unstall_i) st_d = SU_IDLE;
            default:
                st_d = SU_IDLE;
        endcase
    end

    always_comb begin
        ovw_d = ovw_q;
        if (setup_rcvd_i && st_q != SU_IDLE)       ovw_d = 1'b1;
        else if (rd_clear_i && st_q != SU_WRITING) ovw_d = 1'b0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SU_IDLE;
            ovw_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ovw_q <= ovw_d;
        end
    end

    // Outputs
    always_comb begin
        holds_setup_o = (st_q == SU_HELD);
        overwrite_o   = ovw_q;
    end

    assert_overwrite_set_R9: assert property (@(posedge clk) disable iff (rst)
        (setup_rcvd_i && st_q != SU_IDLE) |=> overwrite_o);

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_clear_i && !setup_rcvd_i && st_q != SU_WRITING) |=> !overwrite_o);

    assert_write_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == SU_WRITING && overwrite_o) |=> overwrite_o);

    assert_handled_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == SU_HELD && !setup_rcvd_i && (ep0_stall_i || ep0_unstall_i)) |=> !holds_setup_o);

endmodule

// File: rtl/epstat_ctrl.sv
module epstat_ctrl
    import epstat_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int EPW = $clog2(NUM_EP),
    parameter logic [NUM_EP-1:0] DBL_MASK = {{(NUM_EP-2){1'b1}}, 2'b00}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_byte_i,
    input  logic              setup_rcvd_i,
    input  logic              setup_done_i,
    input  logic              in_sent_i,
    input  logic              out_rcvd_i,
    input  logic [EPW-1:0]    usb_ep_i,
    input  logic              rd_strobe_i,
    input  logic [EPW-1:0]    rd_ep_i,
    output logic [STS_W-1:0]  status_o,
    output logic [NUM_EP-1:0] flush_o
);

    localparam int NUM_CTRL = 2;

    ep_op_e         op;
    logic [EPW-1:0] cmd_ep;
    ep_state_t      ep_st [NUM_EP];
    logic [NUM_EP-1:0] reinit, stall, validate, in_hit, out_hit;
    logic           holds_setup, overwrite;
    logic           ep0_cmd_hit;

    epstat_cmd_decode #(.NUM_EP(NUM_EP)) u_decode (
        .cmd_valid_i (cmd_valid_i),
        .cmd_byte_i  (cmd_byte_i),
        .op_o        (op),
        .ep_o        (cmd_ep)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic cmd_hit;
        logic usb_hit;
        assign cmd_hit     = (cmd_ep == EPW'(g));
        assign usb_hit     = (usb_ep_i == EPW'(g));
        assign reinit[g]   = (setup_rcvd_i && (g < NUM_CTRL)) || (op == OP_UNSTALL && cmd_hit);
        assign stall[g]    = (op == OP_STALL) && cmd_hit;
        assign validate[g] = (op == OP_VALIDATE) && cmd_hit;
        assign in_hit[g]   = in_sent_i && usb_hit;
        assign out_hit[g]  = out_rcvd_i && usb_hit;

        epstat_ep_slice #(.DOUBLE(DBL_MASK[g])) u_slice (
            .clk        (clk),
            .rst        (rst),
            .reinit_i   (reinit[g]),
            .stall_i    (stall[g]),
            .validate_i (validate[g]),
            .in_sent_i  (in_hit[g]),
            .out_rcvd_i (out_hit[g]),
            .st_o       (ep_st[g]),
            .flush_o    (flush_o[g])
        );
    end

    assign ep0_cmd_hit = (cmd_ep == '0);

    epstat_setup_fsm u_setup (
        .clk           (clk),
        .rst           (rst),
        .setup_rcvd_i  (setup_rcvd_i),
        .setup_done_i  (setup_done_i),
        .ep0_stall_i   (op == OP_STALL && ep0_cmd_hit),
        .ep0_unstall_i (op == OP_UNSTALL && ep0_cmd_hit),
        .rd_clear_i    (rd_strobe_i && rd_ep_i == '0),
        .holds_setup_o (holds_setup),
        .overwrite_o   (overwrite)
    );

    // Status byte assembly
    always_comb begin
        ep_state_t sel;
        sel                  = ep_st[rd_ep_i];
        status_o             = '0;
        status_o[BIT_STALL]  = sel.stalled;
        status_o[BIT_FULL_S] = sel.full_sec;
        status_o[BIT_FULL_P] = sel.full_pri;
        status_o[BIT_PID]    = sel.pid;
        status_o[BIT_CPUSEL] = sel.cpu_sel;
        if (rd_ep_i == '0) begin
            status_o[BIT_OVW]   = overwrite;
            status_o[BIT_SETUP] = holds_setup;
        end
    end

    assert_setup_unstalls_R7: assert property (@(posedge clk) disable iff (rst)
        setup_rcvd_i |=> (!ep_st[0].stalled && !ep_st[1].stalled && flush_o[0] && flush_o[1]));

    assert_setup_beats_stall_R12: assert property (@(posedge clk) disable iff (rst)
        (setup_rcvd_i && op == OP_STALL && cmd_ep < EPW'(NUM_CTRL)) |=> !ep_st[cmd_ep[0]].stalled);

endmodule

// File: tb/epstat_ctrl_bench.sv
module epstat_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        setup_rcvd = 1'b0, setup_done = 1'b0;
    logic        in_sent = 1'b0, out_rcvd = 1'b0;
    logic [3:0]  usb_ep = 4'h0;
    logic        rd_strobe = 1'b0;
    logic [3:0]  rd_ep = 4'h0;
    logic [7:0]  status;
    logic [15:0] flush;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    epstat_ctrl u_epstat_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid_i  (cmd_valid),
        .cmd_byte_i   (cmd_byte),
        .setup_rcvd_i (setup_rcvd),
        .setup_done_i (setup_done),
        .in_sent_i    (in_sent),
        .out_rcvd_i   (out_rcvd),
        .usb_ep_i     (usb_ep),
        .rd_strobe_i  (rd_strobe),
        .rd_ep_i      (rd_ep),
        .status_o     (status),
        .flush_o      (flush)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %04h expected %04h", req, got, exp);
        end
    endtask

    task automatic peek(input int ep, output logic [7:0] v);
        rd_ep = 4'(ep);
        #1;
        v = status;
    endtask

    task automatic expect_ep(input string req, input int ep, input logic [7:0] exp);
        logic [7:0] v;
        peek(ep, v);
        check(req, {8'h00, v}, {8'h00, exp});
    endtask

    // Command; returns at the negedge after the sampling edge
    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_in(input int ep);
        @(negedge clk);
        in_sent = 1'b1; usb_ep = 4'(ep);
        @(negedge clk);
        in_sent = 1'b0;
    endtask

    task automatic pulse_out(input int ep);
        @(negedge clk);
        out_rcvd = 1'b1; usb_ep = 4'(ep);
        @(negedge clk);
        out_rcvd = 1'b0;
    endtask

    task automatic pulse_setup();
        @(negedge clk);
        setup_rcvd = 1'b1;
        @(negedge clk);
        setup_rcvd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        setup_done = 1'b1;
        @(negedge clk);
        setup_done = 1'b0;
    endtask

    task automatic read_ep0(output logic [7:0] v);
        @(negedge clk);
        rd_ep = 4'h0; rd_strobe = 1'b1;
        #1 v = status;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        for (int e = 0; e < 16; e++) expect_ep("R1 reset status", e, 8'h00);
        check("R1 reset flush", flush, 16'h0000);
    endtask

    task automatic t_stall_unstall();
        send_cmd(8'h65);
        expect_ep("R4 validate ep5", 5, 8'h22);
        send_cmd(8'h45);
        expect_ep("R2 stall ep5", 5, 8'hA2);
        send_cmd(8'h45);
        expect_ep("R2 re-stall no effect", 5, 8'hA2);
        check("R2 stall raises no flush", flush, 16'h0000);
        send_cmd(8'h85);
        check("R3 unstall flush pulse", flush, 16'h0020);
        expect_ep("R3 unstall reinit", 5, 8'h00);
        @(negedge clk);
        check("R3 flush one cycle", flush, 16'h0000);
        send_cmd(8'h67);
        send_cmd(8'h87);
        check("R3 unstall of non-stalled flushes", flush, 16'h0080);
        expect_ep("R3 unstall of non-stalled reinit", 7, 8'h00);
    endtask

    task automatic t_validate();
        send_cmd(8'h63);
        expect_ep("R4 double first validate", 3, 8'h22);
        send_cmd(8'h63);
        expect_ep("R4 double second validate", 3, 8'h60);
        send_cmd(8'h61);
        expect_ep("R4 single validate", 1, 8'h20);
        send_cmd(8'h61);
        expect_ep("R4 single keeps select", 1, 8'h20);
    endtask

    task automatic t_in_out();
        pulse_in(3);
        expect_ep("R5 send primary", 3, 8'h50);
        pulse_in(3);
        expect_ep("R5 send secondary", 3, 8'h00);
        pulse_in(3);
        expect_ep("R5 send empty ignored", 3, 8'h00);
        pulse_in(1);
        expect_ep("R5 single send", 1, 8'h10);
        pulse_out(9);
        expect_ep("R6 out toggles pid", 9, 8'h10);
        pulse_out(9);
        expect_ep("R6 out toggles back", 9, 8'h00);
    endtask

    task automatic t_undefined();
        send_cmd(8'h62);
        expect_ep("R4 validate ep2", 2, 8'h22);
        foreach (cmd_bytes_bad[i]) begin
            send_cmd(cmd_bytes_bad[i]);
            check("R11 undefined no flush", flush, 16'h0000);
        end
        expect_ep("R11 ep2 unchanged", 2, 8'h22);
        expect_ep("R11 ep0 unchanged", 0, 8'h00);
        expect_ep("R13 other ep setup bits zero", 1, 8'h10);
    endtask

    logic [7:0] cmd_bytes_bad [6] = '{8'h60, 8'h00, 8'h3F, 8'h90, 8'h52, 8'hC2};

    task automatic t_setup();
        logic [7:0] v;
        send_cmd(8'h40);
        send_cmd(8'h41);
        expect_ep("R2 stall ep0", 0, 8'h80);
        expect_ep("R2 stall ep1", 1, 8'h90);
        pulse_setup();
        check("R7 setup flushes both", flush, 16'h0003);
        expect_ep("R7 setup unstalls ep0", 0, 8'h00);
        expect_ep("R7 setup reinit ep1", 1, 8'h00);
        pulse_done();
        expect_ep("R8 setup held", 0, 8'h04);
        pulse_setup();
        expect_ep("R9 overwrite set", 0, 8'h08);
        read_ep0(v);
        check("R10 read while writing value", {8'h00, v}, 16'h0008);
        expect_ep("R10 kept while writing", 0, 8'h08);
        pulse_done();
        expect_ep("R8 held after rewrite", 0, 8'h0C);
        read_ep0(v);
        check("R10 read returns old value", {8'h00, v}, 16'h000C);
        expect_ep("R10 read clears overwrite", 0, 8'h04);
        send_cmd(8'h40);
        expect_ep("R8 stall handles setup", 0, 8'h80);
        send_cmd(8'h80);
        expect_ep("R3 unstall ep0", 0, 8'h00);
        rd_ep = 4'h0;
        #1 check("R13 reserved bit zero", {15'h0, status[0]}, 16'h0000);
    endtask

    task automatic t_priority();
        send_cmd(8'h64);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h44; in_sent = 1'b1; usb_ep = 4'h4;
        @(negedge clk);
        cmd_valid = 1'b0; in_sent = 1'b0;
        expect_ep("R12 command beats in_sent", 4, 8'hA2);
        pulse_in(4);
        expect_ep("R5 send on stalled ep", 4, 8'h92);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h40; setup_rcvd = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; setup_rcvd = 1'b0;
        expect_ep("R12 setup beats stall", 0, 8'h00);
        pulse_done();
        expect_ep("R8 held after setup", 0, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stall_unstall();
        t_validate();
        t_in_out();
        t_undefined();
        t_setup();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule